// File: doc/BRIEF.md
# Cycle-Bit Transfer Ring Consumer

This block walks a ring of 128-bit transfer request blocks (TRBs) kept in a small internal store and hands each one to a downstream engine. Whether a TRB is ready for the consumer is not decided by comparing head and tail pointers. Instead, the consumer compares the TRB's cycle bit with a cycle state it keeps. On a mismatch it stops and waits for the next doorbell.

The ring is made of fixed-size segments joined by link entries. A link entry redirects the dequeue pointer and may invert the expected cycle state. Consecutive chained TRBs form one transfer descriptor (TD). The block raises a one-cycle done pulse carrying the index of the TD's final TRB. No-op entries are consumed without being presented.

Software or a neighbouring block fills the store through a write port. While the consumer is idle, it can also load the dequeue index and cycle state.

Top module: `trc_ring_consumer`

## Requirements
- R1: After reset the dequeue index is 0, the cycle state is 1, and neither `trb_valid` nor `td_done` is asserted.
- R2: A TRB is consumed only when its cycle bit (bit 96 of the entry, which is bit 0 of its control word) equals the cycle state. On a mismatch the block goes idle and leaves the dequeue index and cycle state unchanged.
- R3: From idle, a `doorbell` pulse starts fetching at the dequeue index. A doorbell while fetching has no effect.
- R4: A presented TRB keeps `trb_valid`, `trb_data` and `trb_idx` stable until `trb_ready` is high. The dequeue index advances by one after the handshake.
- R5: A link entry (type 6 in control bits 15:10, so entry bits 111:106) is never presented. Following it loads the dequeue index from byte address word 0 divided by 16, i.e. entry bits [IDX_W+3:4].
- R6: When a link entry's toggle flag (control bit 1, entry bit 97) is set, the cycle state inverts on following the link. When the flag is clear, the cycle state is kept.
- R7: The chain flag is control bit 4 (entry bit 100). `trb_last` is the inverse of the chain flag. On the handshake of a TRB whose chain flag is clear, `td_done` pulses for one cycle in the next cycle, with `td_idx` set to that TRB's index.
- R8: A no-op entry (type 8) is never presented. It advances the dequeue index, and if its chain flag is clear it raises `td_done` with its own index.
- R9: While idle, `ptr_load` sets the dequeue index and cycle state from `ptr_load_idx` and `ptr_load_cyc`. While fetching, `ptr_load` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_we | input | 1 | Write one entry into the ring store |
| ring_waddr | input | IDX_W | Entry index to write |
| ring_wdata | input | 128 | Entry contents (control word in bits 127:96) |
| doorbell | input | 1 | Start fetching when idle |
| ptr_load | input | 1 | Load dequeue index and cycle state (idle only) |
| ptr_load_idx | input | IDX_W | Dequeue index to load |
| ptr_load_cyc | input | 1 | Cycle state to load |
| deq_idx | output | IDX_W | Current dequeue index |
| cyc_state | output | 1 | Current consumer cycle state |
| trb_valid | output | 1 | A TRB is presented |
| trb_ready | input | 1 | Downstream accepts the presented TRB |
| trb_data | output | 128 | Presented TRB |
| trb_idx | output | IDX_W | Index of the presented TRB |
| trb_last | output | 1 | Presented TRB ends its TD |
| td_done | output | 1 | One-cycle pulse at the end of a TD |
| td_idx | output | IDX_W | Index of the TD's final entry |

## Verification
The hardest case to reach is a link entry at the end of a segment that flips the cycle state. The entries beyond the link then must carry the opposite cycle bit to be accepted. The bench loads the dequeue index near the segment boundary and writes entries of both polarities past the link. That way only a correct toggle yields the expected presented sequence and stopping point. Backpressure is held while a doorbell and a pointer load arrive, to show that neither disturbs an active fetch.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] status;
        logic [31:0] ptr_hi;
        logic [31:0] ptr_lo;
    } trb_t;

    localparam logic [5:0] KIND_LINK = 6'd6;
    localparam logic [5:0] KIND_NOOP = 6'd8;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_SCAN,
        FS_HOLD
    } fetch_st_e;

    function automatic logic [5:0] trb_kind(input trb_t t);
        return t.ctrl[15:10];
    endfunction

    function automatic logic trb_cyc(input trb_t t);
        return t.ctrl[0];
    endfunction

    function automatic logic trb_chained(input trb_t t);
        return t.ctrl[4];
    endfunction

    function automatic logic link_flips(input trb_t t);
        return t.ctrl[1];
    endfunction

endpackage

// File: rtl/trc_ring_mem.sv
module trc_ring_mem
    import trc_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  trb_t             wdata,
    input  logic [IDX_W-1:0] raddr,
    output trb_t             rdata
);

    trb_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/trc_fetch_ctl.sv
module trc_fetch_ctl
    import trc_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             doorbell,
    input  logic             ptr_load,
    input  logic [IDX_W-1:0] ptr_load_idx,
    input  logic             ptr_load_cyc,
    output logic [IDX_W-1:0] rd_idx,
    input  trb_t             rd_trb,
    output logic [IDX_W-1:0] deq_idx,
    output logic             cyc_state,
    output logic             trb_valid,
    input  logic             trb_ready,
    output trb_t             trb_data,
    output logic [IDX_W-1:0] trb_idx,
    output logic             trb_last,
    output logic             td_done,
    output logic [IDX_W-1:0] td_idx
);

    fetch_st_e        st;
    logic [IDX_W-1:0] deq_q;
    logic             cyc_q;
    trb_t             hold_trb;
    logic [IDX_W-1:0] hold_idx;
    logic [IDX_W-1:0] link_target;

    assign link_target = rd_trb.ptr_lo[IDX_W+3:4];
    assign rd_idx      = deq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= FS_IDLE;
            deq_q    <= '0;
            cyc_q    <= 1'b1;
            hold_trb <= '0;
            hold_idx <= '0;
            td_done  <= 1'b0;
            td_idx   <= '0;
        end else begin
            td_done <= 1'b0;
            unique case (st)
                FS_IDLE: begin
                    if (ptr_load) begin
                        deq_q <= ptr_load_idx;
                        cyc_q <= ptr_load_cyc;
                    end
                    if (doorbell) st <= FS_SCAN;
                end
                FS_SCAN: begin
                    if (trb_cyc(rd_trb) != cyc_q) begin
                        st <= FS_IDLE;
                    end else if (trb_kind(rd_trb) == KIND_LINK) begin
                        deq_q <= link_target;
                        cyc_q <= cyc_q ^ link_flips(rd_trb);
                    end else if (trb_kind(rd_trb) == KIND_NOOP) begin
                        deq_q <= deq_q + 1'b1;
                        if (!trb_chained(rd_trb)) begin
                            td_done <= 1'b1;
                            td_idx  <= deq_q;
                        end
                    end else begin
                        hold_trb <= rd_trb;
                        hold_idx <= deq_q;
                        st       <= FS_HOLD;
                    end
                end
                FS_HOLD: begin
                    if (trb_ready) begin
                        deq_q <= deq_q + 1'b1;
                        st    <= FS_SCAN;
                        if (!trb_chained(hold_trb)) begin
                            td_done <= 1'b1;
                            td_idx  <= hold_idx;
                        end
                    end
                end
                default: st <= FS_IDLE;
            endcase
        end
    end

    assign deq_idx   = deq_q;
    assign cyc_state = cyc_q;
    assign trb_valid = (st == FS_HOLD);
    assign trb_data  = hold_trb;
    assign trb_idx   = hold_idx;
    assign trb_last  = !trb_chained(hold_trb);

    // R2
    owned_only_chk: assert property (@(posedge clk) disable iff (rst)
        trb_valid |-> (trb_data.ctrl[0] == cyc_state));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (trb_valid && !trb_ready) |=> (trb_valid && $stable(trb_idx) && $stable(trb_data)));

    // R5
    no_link_out_chk: assert property (@(posedge clk) disable iff (rst)
        trb_valid |-> (trb_data.ctrl[15:10] != KIND_LINK));

    // R8
    no_noop_out_chk: assert property (@(posedge clk) disable iff (rst)
        trb_valid |-> (trb_data.ctrl[15:10] != KIND_NOOP));

    // R9
    load_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (trb_valid && !trb_ready) |=> ($stable(deq_idx) && $stable(cyc_state)));

endmodule

// File: rtl/trc_ring_consumer.sv
module trc_ring_consumer
    import trc_pkg::*;
#(
    parameter int SEG_TRBS = 64,
    parameter int NUM_SEGS = 2,
    localparam int DEPTH = SEG_TRBS * NUM_SEGS,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ring_we,
    input  logic [IDX_W-1:0] ring_waddr,
    input  logic [127:0]     ring_wdata,
    input  logic             doorbell,
    input  logic             ptr_load,
    input  logic [IDX_W-1:0] ptr_load_idx,
    input  logic             ptr_load_cyc,
    output logic [IDX_W-1:0] deq_idx,
    output logic             cyc_state,
    output logic             trb_valid,
    input  logic             trb_ready,
    output logic [127:0]     trb_data,
    output logic [IDX_W-1:0] trb_idx,
    output logic             trb_last,
    output logic             td_done,
    output logic [IDX_W-1:0] td_idx
);

    logic [IDX_W-1:0] rd_idx;
    trb_t             rd_trb;
    trb_t             out_trb;

    trc_ring_mem #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (ring_we),
        .waddr (ring_waddr),
        .wdata (trb_t'(ring_wdata)),
        .raddr (rd_idx),
        .rdata (rd_trb)
    );

    trc_fetch_ctl #(.IDX_W(IDX_W)) u_ctl (
        .clk          (clk),
        .rst          (rst),
        .doorbell     (doorbell),
        .ptr_load     (ptr_load),
        .ptr_load_idx (ptr_load_idx),
        .ptr_load_cyc (ptr_load_cyc),
        .rd_idx       (rd_idx),
        .rd_trb       (rd_trb),
        .deq_idx      (deq_idx),
        .cyc_state    (cyc_state),
        .trb_valid    (trb_valid),
        .trb_ready    (trb_ready),
        .trb_data     (out_trb),
        .trb_idx      (trb_idx),
        .trb_last     (trb_last),
        .td_done      (td_done),
        .td_idx       (td_idx)
    );

    assign trb_data = out_trb;

endmodule

// File: tb/trc_ring_consumer_tb.sv
module trc_ring_consumer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 7;

    logic             clk = 0;
    logic             rst = 1;
    logic             ring_we = 0;
    logic [IDX_W-1:0] ring_waddr = '0;
    logic [127:0]     ring_wdata = '0;
    logic             doorbell = 0;
    logic             ptr_load = 0;
    logic [IDX_W-1:0] ptr_load_idx = '0;
    logic             ptr_load_cyc = 0;
    logic [IDX_W-1:0] deq_idx;
    logic             cyc_state;
    logic             trb_valid;
    logic             trb_ready = 0;
    logic [127:0]     trb_data;
    logic [IDX_W-1:0] trb_idx;
    logic             trb_last;
    logic             td_done;
    logic [IDX_W-1:0] td_idx;

    int total = 0;
    int bad = 0;
    int n_pres = 0;
    int n_done = 0;
    int pres_idx [32];
    int pres_last [32];
    int done_idx [32];
    logic [31:0] first_ctrl;

    trc_ring_consumer u_dut (
        .clk(clk), .rst(rst), .ring_we(ring_we), .ring_waddr(ring_waddr),
        .ring_wdata(ring_wdata), .doorbell(doorbell), .ptr_load(ptr_load),
        .ptr_load_idx(ptr_load_idx), .ptr_load_cyc(ptr_load_cyc),
        .deq_idx(deq_idx), .cyc_state(cyc_state), .trb_valid(trb_valid),
        .trb_ready(trb_ready), .trb_data(trb_data), .trb_idx(trb_idx),
        .trb_last(trb_last), .td_done(td_done), .td_idx(td_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst && trb_valid && trb_ready && n_pres < 32) begin
            if (n_pres == 0) first_ctrl = trb_data[127:96];
            pres_idx[n_pres]  = int'(trb_idx);
            pres_last[n_pres] = int'(trb_last);
            n_pres++;
        end
        if (!rst && td_done && n_done < 32) begin
            done_idx[n_done] = int'(td_idx);
            n_done++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(input int kind, input bit cyc, input bit chain, input bit tog);
        return (32'(kind) << 10) | (32'(chain) << 4) | (32'(tog) << 1) | 32'(cyc);
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int idx, input logic [31:0] c, input logic [31:0] p);
        ring_we = 1; ring_waddr = IDX_W'(idx); ring_wdata = {c, 32'h0, 32'h0, p};
        step(1);
        ring_we = 0;
    endtask

    task automatic ring_bell();
        n_pres = 0; n_done = 0;
        doorbell = 1; step(1); doorbell = 0;
    endtask

    task automatic load_ptr(input int idx, input bit c);
        ptr_load = 1; ptr_load_idx = IDX_W'(idx); ptr_load_cyc = c;
        step(1);
        ptr_load = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(deq_idx == 0, "R1 deq", int'(deq_idx), 0);
        chk(cyc_state == 1, "R1 cyc", int'(cyc_state), 1);
        chk(!trb_valid && !td_done, "R1 idle outputs", int'(trb_valid), 0);
    endtask

    task automatic t_basic();
        wr(0, ctl(1, 1, 1, 0), 0);
        wr(1, ctl(1, 1, 1, 0), 0);
        wr(2, ctl(1, 1, 0, 0), 0);
        trb_ready = 1;
        ring_bell();
        step(30);
        @(negedge clk);
        chk(n_pres == 3, "R2 presented count", n_pres, 3);
        chk(pres_idx[0] == 0 && pres_idx[2] == 2, "R3 order", pres_idx[2], 2);
        chk(first_ctrl == ctl(1, 1, 1, 0), "R4 data", int'(first_ctrl), int'(ctl(1, 1, 1, 0)));
        chk(pres_last[1] == 0 && pres_last[2] == 1, "R7 last flag", pres_last[2], 1);
        chk(n_done == 1 && done_idx[0] == 2, "R7 td done", done_idx[0], 2);
        chk(deq_idx == 3 && cyc_state == 1, "R2 stop at mismatch", int'(deq_idx), 3);
    endtask

    task automatic t_noop();
        wr(3, ctl(8, 1, 0, 0), 0);
        wr(4, ctl(1, 1, 0, 0), 0);
        ring_bell();
        step(30);
        @(negedge clk);
        chk(n_pres == 1 && pres_idx[0] == 4, "R8 noop skipped", pres_idx[0], 4);
        chk(n_done == 2 && done_idx[0] == 3 && done_idx[1] == 4, "R8 noop done", done_idx[0], 3);
        chk(deq_idx == 5, "R8 deq", int'(deq_idx), 5);
    endtask

    task automatic t_backpressure();
        wr(5, ctl(1, 1, 0, 0), 0);
        trb_ready = 0;
        ring_bell();
        step(5);
        @(negedge clk);
        chk(trb_valid && trb_idx == 5, "R4 held", int'(trb_idx), 5);
        step(1);
        load_ptr(99, 0);
        ring_bell();
        step(3);
        @(negedge clk);
        chk(trb_valid && trb_idx == 5, "R4 still held", int'(trb_idx), 5);
        step(1);
        trb_ready = 1;
        step(20);
        @(negedge clk);
        chk(n_pres == 1 && deq_idx == 6, "R9 load ignored when busy", int'(deq_idx), 6);
        chk(cyc_state == 1, "R3 doorbell while busy", int'(cyc_state), 1);
    endtask

    task automatic t_link_toggle();
        wr(60, ctl(1, 1, 0, 0), 0);
        wr(61, ctl(6, 1, 0, 1), 32'd1024);
        wr(64, ctl(1, 0, 0, 0), 0);
        wr(65, ctl(1, 1, 0, 0), 0);
        load_ptr(60, 1);
        chk(deq_idx == 60, "R9 load idle", int'(deq_idx), 60);
        ring_bell();
        step(30);
        @(negedge clk);
        chk(n_pres == 2 && pres_idx[1] == 64, "R5 link followed", pres_idx[1], 64);
        chk(cyc_state == 0, "R6 toggled", int'(cyc_state), 0);
        chk(deq_idx == 65, "R6 stop after toggle", int'(deq_idx), 65);
    endtask

    task automatic t_link_keep();
        wr(70, ctl(6, 0, 0, 0), 32'd0);
        load_ptr(70, 0);
        ring_bell();
        step(20);
        @(negedge clk);
        chk(n_pres == 0, "R5 link not presented", n_pres, 0);
        chk(deq_idx == 0 && cyc_state == 0, "R6 no toggle", int'(cyc_state), 0);
        ring_bell();
        step(10);
        @(negedge clk);
        chk(n_pres == 0 && deq_idx == 0, "R2 mismatch idle", int'(deq_idx), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        rst = 0;
        t_reset();
        for (int i = 0; i < 128; i++) wr(i, 32'h0, 32'h0);
        t_basic();
        t_noop();
        t_backpressure();
        t_link_toggle();
        t_link_keep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule